// File: doc/BRIEF.md
# Steered Banked Issue Window

This block is the scheduling window of an out-of-order core. It is divided into banks, and each bank belongs to one functional unit. An arriving instruction is sent to a bank by its opcode. It waits there until both of its source tags have been produced, and then it is handed to that bank's unit. Each bank keeps its own small picker and looks only at its own entries, so the choice of the next instruction is narrow and quick.

The upstream stage offers one instruction per cycle. If the bank the opcode points to has no free entry, the block raises a stall. The upstream stage then keeps the instruction on the allocate port until the stall drops, and this happens even when another bank still has space. Results are announced as destination tags on a single broadcast bus, and every bank sees that bus in the same cycle. The window stores no operand values, and it contains no execution logic.

Top module: `steered_issue_window`

## Requirements
- R1: Opcode bit 3 selects the bank. A value of 0 steers the instruction to bank 0 (the ALU bank), and a value of 1 steers it to bank 1 (the memory bank). An instruction is issued only from the bank it was steered to.
- R2: An instruction is accepted on a rising edge when `alloc_valid` is high and `alloc_stall` is low. It is written into the lowest-numbered free entry of its bank. An instruction that is not accepted leaves no trace.
- R3: An entry whose two sources are both ready drives its bank's issue outputs in the cycle after the edge on which it became ready. It leaves the bank on the edge that ends its issue cycle.
- R4: `alloc_stall` is high exactly when `alloc_valid` is high and every entry of the target bank is occupied. The other bank's occupancy has no effect on it.
- R5: Each bank issues at most one entry per cycle and always picks the ready entry with the lowest index. `issue_valid[b]` is bank b's issue flag, and bank b's fields sit at `[b*W +: W]` of the flattened issue buses.
- R6: A broadcast tag marks a matching waiting source as ready in every bank on the same edge. A tag that does not match leaves the entry waiting.
- R7: An instruction that is allocated in the same cycle as a broadcast of one of its source tags is stored with that source already ready.
- R8: An entry freed by an issue can take a new instruction only from the next cycle on. A full bank that issues in a cycle still stalls an allocation in that same cycle.
- R9: After reset every bank is empty, no issue flag is raised, and the stall is low while no allocation is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_op | input | OP_W | Opcode; bit SEL_LSB steers the instruction to a bank |
| alloc_dst | input | TAG_W | Destination tag |
| alloc_src1 | input | TAG_W | First source tag |
| alloc_src1_rdy | input | 1 | First source is already available |
| alloc_src2 | input | TAG_W | Second source tag |
| alloc_src2_rdy | input | 1 | Second source is already available |
| alloc_stall | output | 1 | Target bank is full; the offered instruction must be held |
| bcast_valid | input | 1 | A result tag is broadcast this cycle |
| bcast_tag | input | TAG_W | Broadcast destination tag |
| issue_valid | output | NUM_BANKS | Per-bank issue flag |
| issue_op | output | NUM_BANKS*OP_W | Issued opcode per bank |
| issue_dst | output | NUM_BANKS*TAG_W | Issued destination tag per bank |
| issue_src1 | output | NUM_BANKS*TAG_W | Issued first source tag per bank |
| issue_src2 | output | NUM_BANKS*TAG_W | Issued second source tag per bank |

## Verification
Several functions of the block can land in the same cycle, and two collisions need attention. The first is an allocation that carries a source tag while the broadcast bus announces that same tag. The second is an issue from a full bank while an allocation is aimed at that bank. Both are set up directly: an allocation is driven together with a matching broadcast, and a stalled instruction is held while the full bank is woken and drains. A randomized phase over a small tag space then makes both collisions frequent. A behavioural model of entry occupancy and readiness predicts, for every cycle, the stall, each bank's issue flag, and each bank's issued fields.

// File: rtl/rs_pkg.sv
package rs_pkg;
   // Smallest legal widths accepted by the window
   localparam int unsigned MIN_TAG_W   = 1;
   localparam int unsigned MIN_ENTRIES = 2;

   typedef enum logic [0:0] {
      UNIT_ALU = 1'b0,
      UNIT_MEM = 1'b1
   } unit_e;
endpackage

// File: rtl/rs_picker.sv
// Fixed-priority picker: grants the lowest set request bit
module rs_picker #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_pri
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/rs_steer.sv
// Opcode-based steering and per-bank write enables
module rs_steer #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned OP_W      = 4,
   parameter int unsigned SEL_LSB   = 3,
   localparam int unsigned BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 alloc_valid,
   input  logic [OP_W-1:0]      alloc_op,
   input  logic [NUM_BANKS-1:0] bank_full,
   output logic [NUM_BANKS-1:0] bank_wr,
   output logic                 stall
);
   logic [BANK_W-1:0] bank_sel;

   if (NUM_BANKS == 1) begin : g_single
      assign bank_sel = '0;
   end else begin : g_multi
      assign bank_sel = alloc_op[SEL_LSB +: BANK_W];
   end

   assign stall = alloc_valid & bank_full[bank_sel];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
      assign bank_wr[b] = alloc_valid & (bank_sel == BANK_W'(b)) & ~bank_full[b];
   end
endmodule

// File: rtl/rs_bank.sv
// One bank: entry storage, tag wakeup, free-slot choice, issue selection
module rs_bank #(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned OP_W    = 4,
   parameter int unsigned TAG_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [OP_W-1:0]  wr_op,
   input  logic [TAG_W-1:0] wr_dst,
   input  logic [TAG_W-1:0] wr_s1,
   input  logic             wr_r1,
   input  logic [TAG_W-1:0] wr_s2,
   input  logic             wr_r2,
   input  logic             bc_valid,
   input  logic [TAG_W-1:0] bc_tag,
   output logic             full,
   output logic             iss_valid,
   output logic [OP_W-1:0]  iss_op,
   output logic [TAG_W-1:0] iss_dst,
   output logic [TAG_W-1:0] iss_s1,
   output logic [TAG_W-1:0] iss_s2
);
   logic [ENTRIES-1:0] vld_q, rdy1_q, rdy2_q;
   logic [OP_W-1:0]    op_q   [ENTRIES];
   logic [TAG_W-1:0]   dst_q  [ENTRIES];
   logic [TAG_W-1:0]   src1_q [ENTRIES];
   logic [TAG_W-1:0]   src2_q [ENTRIES];

   logic [ENTRIES-1:0] ready_vec, gnt, slot_oh;
   logic               slot_any;
   logic               new_hit1, new_hit2;

   assign ready_vec = vld_q & rdy1_q & rdy2_q;
   assign full      = &vld_q;
   assign new_hit1  = bc_valid & (wr_s1 == bc_tag);
   assign new_hit2  = bc_valid & (wr_s2 == bc_tag);

   rs_picker #(.N(ENTRIES)) u_issue_pick (
      .req (ready_vec),
      .gnt (gnt),
      .any (iss_valid)
   );

   rs_picker #(.N(ENTRIES)) u_slot_pick (
      .req (~vld_q),
      .gnt (slot_oh),
      .any (slot_any)
   );

   // Status: occupancy and operand readiness
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rdy1_q <= '0;
         rdy2_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && slot_any && slot_oh[i]) begin
               vld_q[i]  <= 1'b1;
               rdy1_q[i] <= wr_r1 | new_hit1;
               rdy2_q[i] <= wr_r2 | new_hit2;
            end else begin
               if (gnt[i]) begin
                  vld_q[i] <= 1'b0;
               end
               if (bc_valid && src1_q[i] == bc_tag) begin
                  rdy1_q[i] <= 1'b1;
               end
               if (bc_valid && src2_q[i] == bc_tag) begin
                  rdy2_q[i] <= 1'b1;
               end
            end
         end
      end
   end

   // Payload: written only on allocation
   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_en && slot_any && slot_oh[i]) begin
            op_q[i]   <= wr_op;
            dst_q[i]  <= wr_dst;
            src1_q[i] <= wr_s1;
            src2_q[i] <= wr_s2;
         end
      end
   end

   // One-hot issue multiplexer
   always_comb begin
      iss_op  = '0;
      iss_dst = '0;
      iss_s1  = '0;
      iss_s2  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (gnt[i]) begin
            iss_op  = iss_op  | op_q[i];
            iss_dst = iss_dst | dst_q[i];
            iss_s1  = iss_s1  | src1_q[i];
            iss_s2  = iss_s2  | src2_q[i];
         end
      end
   end
endmodule

// File: rtl/steered_issue_window.sv
module steered_issue_window #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ENTRIES   = 4,
   parameter int unsigned OP_W      = 4,
   parameter int unsigned TAG_W     = 6,
   parameter int unsigned SEL_LSB   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_valid,
   input  logic [OP_W-1:0]            alloc_op,
   input  logic [TAG_W-1:0]           alloc_dst,
   input  logic [TAG_W-1:0]           alloc_src1,
   input  logic                       alloc_src1_rdy,
   input  logic [TAG_W-1:0]           alloc_src2,
   input  logic                       alloc_src2_rdy,
   output logic                       alloc_stall,
   input  logic                       bcast_valid,
   input  logic [TAG_W-1:0]           bcast_tag,
   output logic [NUM_BANKS-1:0]       issue_valid,
   output logic [NUM_BANKS*OP_W-1:0]  issue_op,
   output logic [NUM_BANKS*TAG_W-1:0] issue_dst,
   output logic [NUM_BANKS*TAG_W-1:0] issue_src1,
   output logic [NUM_BANKS*TAG_W-1:0] issue_src2
);
   import rs_pkg::*;

   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   // Elaboration-time parameter checks
   if (NUM_BANKS < 1 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (SEL_LSB + BANK_W > OP_W) begin : g_bad_sel
      $error("bank select field lies outside the opcode");
   end
   if (ENTRIES < MIN_ENTRIES || TAG_W < MIN_TAG_W) begin : g_bad_size
      $error("bank depth or tag width too small");
   end

   logic [NUM_BANKS-1:0] bank_full, bank_wr;

   rs_steer #(
      .NUM_BANKS (NUM_BANKS),
      .OP_W      (OP_W),
      .SEL_LSB   (SEL_LSB)
   ) u_steer (
      .alloc_valid (alloc_valid),
      .alloc_op    (alloc_op),
      .bank_full   (bank_full),
      .bank_wr     (bank_wr),
      .stall       (alloc_stall)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rs_bank #(
         .ENTRIES (ENTRIES),
         .OP_W    (OP_W),
         .TAG_W   (TAG_W)
      ) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (bank_wr[b]),
         .wr_op     (alloc_op),
         .wr_dst    (alloc_dst),
         .wr_s1     (alloc_src1),
         .wr_r1     (alloc_src1_rdy),
         .wr_s2     (alloc_src2),
         .wr_r2     (alloc_src2_rdy),
         .bc_valid  (bcast_valid),
         .bc_tag    (bcast_tag),
         .full      (bank_full[b]),
         .iss_valid (issue_valid[b]),
         .iss_op    (issue_op[b*OP_W +: OP_W]),
         .iss_dst   (issue_dst[b*TAG_W +: TAG_W]),
         .iss_s1    (issue_src1[b*TAG_W +: TAG_W]),
         .iss_s2    (issue_src2[b*TAG_W +: TAG_W])
      );
   end
endmodule

// File: rtl/rs_chk.sv
// Port-level checker with its own occupancy tally per bank
module rs_chk #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned ENTRIES   = 4,
   parameter int unsigned OP_W      = 4,
   parameter int unsigned SEL_LSB   = 3
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      alloc_valid,
   input logic [OP_W-1:0]           alloc_op,
   input logic                      alloc_stall,
   input logic [NUM_BANKS-1:0]      issue_valid,
   input logic [NUM_BANKS*OP_W-1:0] issue_op
);
   localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int unsigned CNT_W  = $clog2(ENTRIES + 1);

   logic [BANK_W-1:0] tgt;
   assign tgt = (NUM_BANKS > 1) ? alloc_op[SEL_LSB +: BANK_W] : '0;

   // R4
   stall_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |-> alloc_valid);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
      logic [CNT_W-1:0] occ;
      logic             acc;
      assign acc = alloc_valid & ~alloc_stall & (tgt == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) occ <= '0;
         else        occ <= occ + CNT_W'(acc) - CNT_W'(issue_valid[b]);
      end

      // R1
      steer_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid[b] |-> (issue_op[b*OP_W + SEL_LSB +: BANK_W] == BANK_W'(b)));

      // R2
      occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         occ <= CNT_W'(ENTRIES));

      // R4
      full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (alloc_valid && tgt == BANK_W'(b) && occ == CNT_W'(ENTRIES)) |-> alloc_stall);

      // R4
      free_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (alloc_valid && tgt == BANK_W'(b) && occ < CNT_W'(ENTRIES)) |-> !alloc_stall);

      // R5
      issue_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
         issue_valid[b] |-> (occ != '0));

      // R3
      issue_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (issue_valid[b] && occ == CNT_W'(1) && !acc) |=> !issue_valid[b]);
   end
endmodule

bind steered_issue_window rs_chk #(
   .NUM_BANKS (NUM_BANKS),
   .ENTRIES   (ENTRIES),
   .OP_W      (OP_W),
   .SEL_LSB   (SEL_LSB)
) u_rs_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .alloc_valid (alloc_valid),
   .alloc_op    (alloc_op),
   .alloc_stall (alloc_stall),
   .issue_valid (issue_valid),
   .issue_op    (issue_op)
);

// File: tb/steered_issue_window_tb_top.sv
`timescale 1ns/100ps
module steered_issue_window_tb_top;
   localparam int NB = 2;
   localparam int NE = 4;
   localparam int OW = 4;
   localparam int TW = 6;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            a_valid = 1'b0;
   logic [OW-1:0]   a_op = '0;
   logic [TW-1:0]   a_dst = '0, a_s1 = '0, a_s2 = '0;
   logic            a_r1 = 1'b0, a_r2 = 1'b0;
   logic            b_valid = 1'b0;
   logic [TW-1:0]   b_tag = '0;
   logic            alloc_stall;
   logic [NB-1:0]   issue_valid;
   logic [NB*OW-1:0] issue_op;
   logic [NB*TW-1:0] issue_dst, issue_src1, issue_src2;

   always #2 clk = ~clk;

   steered_issue_window dut_i (
      .clk (clk), .rst_n (rst_n),
      .alloc_valid (a_valid), .alloc_op (a_op), .alloc_dst (a_dst),
      .alloc_src1 (a_s1), .alloc_src1_rdy (a_r1),
      .alloc_src2 (a_s2), .alloc_src2_rdy (a_r2),
      .alloc_stall (alloc_stall),
      .bcast_valid (b_valid), .bcast_tag (b_tag),
      .issue_valid (issue_valid), .issue_op (issue_op), .issue_dst (issue_dst),
      .issue_src1 (issue_src1), .issue_src2 (issue_src2)
   );

   int checks = 0;
   int failures = 0;
   string cur_tag = "R5";
   bit last_stall = 1'b0;

   // Reference model state
   int m_v [NB][NE];
   int m_op [NB][NE];
   int m_dst [NB][NE];
   int m_s1 [NB][NE];
   int m_s2 [NB][NE];
   int m_r1 [NB][NE];
   int m_r2 [NB][NE];

   task automatic chk(string req, bit ok, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      a_valid = 1'b0;
      b_valid = 1'b0;
   endtask

   task automatic set_alloc(int op, int dst, int s1, int r1, int s2, int r2);
      a_valid = 1'b1;
      a_op = OW'(op); a_dst = TW'(dst);
      a_s1 = TW'(s1); a_r1 = r1[0];
      a_s2 = TW'(s2); a_r2 = r2[0];
   endtask

   // Called just after a falling edge with inputs set; compares, advances model
   task automatic cycle();
      int g [NB];
      bit fl [NB];
      bit es;
      int tb;
      int slot;
      #1;
      for (int b = 0; b < NB; b++) begin
         g[b] = -1;
         fl[b] = 1'b1;
         for (int i = 0; i < NE; i++) begin
            if (m_v[b][i] == 0) fl[b] = 1'b0;
            if (g[b] < 0 && m_v[b][i] != 0 && m_r1[b][i] != 0 && m_r2[b][i] != 0) g[b] = i;
         end
      end
      tb = int'(a_op[3]);
      es = a_valid && fl[tb];
      chk("R4 R8 stall", alloc_stall == es, alloc_stall, es);
      for (int b = 0; b < NB; b++) begin
         chk({cur_tag, " issue_valid"}, issue_valid[b] == (g[b] >= 0), issue_valid[b], g[b] >= 0);
         if (g[b] >= 0 && issue_valid[b]) begin
            chk({cur_tag, " issue_dst"}, int'(issue_dst[b*TW +: TW]) == m_dst[b][g[b]],
                issue_dst[b*TW +: TW], m_dst[b][g[b]]);
            chk({cur_tag, " issue_op"}, int'(issue_op[b*OW +: OW]) == m_op[b][g[b]],
                issue_op[b*OW +: OW], m_op[b][g[b]]);
            chk({cur_tag, " issue_src1"}, int'(issue_src1[b*TW +: TW]) == m_s1[b][g[b]],
                issue_src1[b*TW +: TW], m_s1[b][g[b]]);
         end
      end
      slot = -1;
      if (a_valid && !es)
         for (int i = 0; i < NE; i++)
            if (slot < 0 && m_v[tb][i] == 0) slot = i;
      for (int b = 0; b < NB; b++)
         for (int i = 0; i < NE; i++) begin
            if (i == g[b]) m_v[b][i] = 0;
            else if (m_v[b][i] != 0 && b_valid) begin
               if (m_s1[b][i] == int'(b_tag)) m_r1[b][i] = 1;
               if (m_s2[b][i] == int'(b_tag)) m_r2[b][i] = 1;
            end
         end
      if (slot >= 0) begin
         m_v[tb][slot] = 1;
         m_op[tb][slot] = int'(a_op); m_dst[tb][slot] = int'(a_dst);
         m_s1[tb][slot] = int'(a_s1); m_s2[tb][slot] = int'(a_s2);
         m_r1[tb][slot] = (a_r1 || (b_valid && a_s1 == b_tag)) ? 1 : 0;
         m_r2[tb][slot] = (a_r2 || (b_valid && a_s2 == b_tag)) ? 1 : 0;
      end
      last_stall = es;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int b = 0; b < NB; b++)
         for (int i = 0; i < NE; i++) m_v[b][i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      #0.3;
      chk("R9 issue after reset", issue_valid == '0, issue_valid, 0);
      chk("R9 stall after reset", alloc_stall == 1'b0, alloc_stall, 0);
      cycle();

      // R1: steering by opcode bit 3
      cur_tag = "R1";
      set_alloc(4'h2, 5, 1, 1, 2, 1); cycle();
      idle(); #0.3;
      chk("R1 alu bank issue", issue_valid == 2'b01, issue_valid, 1);
      chk("R1 alu dst", issue_dst[5:0] == 6'd5, issue_dst[5:0], 5);
      cycle();
      set_alloc(4'hA, 6, 1, 1, 2, 1); cycle();
      idle(); #0.3;
      chk("R1 mem bank issue", issue_valid == 2'b10, issue_valid, 2);
      cycle();

      // R4, R8, R5: fill memory bank, hold a stalled instruction
      cur_tag = "R5";
      for (int k = 0; k < NE; k++) begin
         set_alloc(8 + k, 10 + k, 20, 0, 1, 1); cycle();
      end
      set_alloc(4'hC, 14, 21, 1, 22, 1); #0.3;
      chk("R4 full target bank stalls", alloc_stall == 1'b1, alloc_stall, 1);
      cycle();
      set_alloc(4'h1, 15, 1, 1, 2, 1); #0.3;
      chk("R4 other bank not stalled", alloc_stall == 1'b0, alloc_stall, 0);
      cycle();
      set_alloc(4'hC, 14, 21, 1, 22, 1);
      b_valid = 1'b1; b_tag = 6'd20;
      cycle();
      b_valid = 1'b0; #0.3;
      chk("R8 issuing full bank still stalls", alloc_stall == 1'b1, alloc_stall, 1);
      chk("R6 woken bank issues", issue_valid[1] == 1'b1, issue_valid[1], 1);
      cycle();
      #0.3;
      chk("R8 freed slot accepts next cycle", alloc_stall == 1'b0, alloc_stall, 0);
      cycle();
      idle();
      repeat (6) cycle();

      // R7: allocation together with a matching broadcast
      cur_tag = "R7";
      set_alloc(4'h3, 30, 33, 0, 34, 1);
      b_valid = 1'b1; b_tag = 6'd33;
      cycle();
      idle(); #0.3;
      chk("R7 same-cycle wakeup", issue_valid[0] == 1'b1, issue_valid[0], 1);
      chk("R7 dst", issue_dst[5:0] == 6'd30, issue_dst[5:0], 30);
      cycle();

      // R6: non-matching tag leaves entry waiting, matching tag wakes it
      cur_tag = "R6";
      set_alloc(4'h3, 31, 35, 0, 1, 1);
      b_valid = 1'b1; b_tag = 6'd36;
      cycle();
      idle(); #0.3;
      chk("R6 mismatch keeps waiting", issue_valid[0] == 1'b0, issue_valid[0], 0);
      cycle();
      b_valid = 1'b1; b_tag = 6'd35;
      cycle();
      idle(); #0.3;
      chk("R6 match wakes entry", issue_valid[0] == 1'b1, issue_valid[0], 1);
      cycle();

      // R6: one broadcast wakes both banks
      set_alloc(4'h4, 40, 41, 0, 1, 1); cycle();
      set_alloc(4'h9, 42, 41, 0, 1, 1); cycle();
      idle(); b_valid = 1'b1; b_tag = 6'd41; cycle();
      idle(); #0.3;
      chk("R6 both banks issue together", issue_valid == 2'b11, issue_valid, 3);
      cycle();
      cycle();

      // R2: randomized traffic with held stalls
      cur_tag = "R2";
      for (int n = 0; n < 600; n++) begin
         if (!last_stall) begin
            if ($urandom_range(9) < 7)
               set_alloc($urandom_range(15), $urandom_range(63), $urandom_range(15),
                         $urandom_range(3) == 0, $urandom_range(15), $urandom_range(1));
            else
               a_valid = 1'b0;
         end
         b_valid = ($urandom_range(9) < 5);
         b_tag = TW'($urandom_range(15));
         cycle();
      end
      idle();
      for (int t = 0; t < 16; t++) begin
         b_valid = 1'b1; b_tag = TW'(t); cycle();
      end
      idle();
      repeat (10) cycle();

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule